// File: doc/BRIEF.md
# Variable Pulse Width Symbol Encoder

This block drives one wire of a variable-pulse-width bus from a stream of requested symbols. A requester offers one symbol at a time over a valid/ready handshake: start-of-frame, a data bit, end-of-data or break. The encoder sets the line level and holds it for the symbol's length, counted in one-microsecond ticks supplied on `tick_us`. Start-of-frame and break are active. End-of-data is passive. A data bit always takes the level opposite to the present line, so each bit boundary is a transition. The bit's length then depends on both its value and that level.

When end-of-data or break has run out and nothing more is offered, the encoder extends the passive time by itself. This covers the end-of-frame and inter-frame separation time without any further transition. It then returns to idle. `busy` marks the span from the first accepted symbol to the end of that separation time.

Top module: `vpw_sym_encoder`

## Requirements
- R1: After synchronous reset the line is passive (`line_active` = 0), `busy` is low and `sym_ready` is high.
- R2: A start-of-frame (`sym_kind` = 0) drives the line active for 200 ticks from its acceptance.
- R3: A data bit (`sym_kind` = 1) drives the line to the inverse of its level at acceptance, so the first bit after a start-of-frame is passive.
- R4: A data bit driven passive lasts 128 ticks for value 1 and 64 ticks for value 0 (`sym_bit`). A data bit driven active lasts 64 ticks for value 1 and 128 ticks for value 0.
- R5: An end-of-data (`sym_kind` = 2) drives the line passive for 200 ticks.
- R6: If no symbol is accepted when an end-of-data has run out, the next tick begins an extension. The line stays passive with no transition, 300 ticks in total from the end-of-data's acceptance. `sym_ready` is low during the extension, and `busy` falls on the clock after the 300th tick.
- R7: A symbol offered when an end-of-data has just run out is accepted before the next tick, and the frame continues with no extension.
- R8: A break (`sym_kind` = 3) drives the line active for exactly 240 ticks. When it has run out with nothing accepted, the line goes passive for 300 ticks, then the encoder returns to idle: 540 ticks from acceptance.
- R9: `sym_ready` is high only in idle or once the current symbol's count has run out. A start-of-frame or data bit that has run out holds its level, and `sym_ready` stays high, until the next symbol is accepted.
- R10: Counting advances only on cycles with `tick_us` high, and nothing is accepted while `sym_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe per microsecond |
| sym_valid | input | 1 | Symbol request offered |
| sym_kind | input | 2 | 0 start-of-frame, 1 data bit, 2 end-of-data, 3 break |
| sym_bit | input | 1 | Data bit value, used when `sym_kind` = 1 |
| sym_ready | output | 1 | Encoder can take a symbol this cycle |
| line_active | output | 1 | Bus drive, 1 = active |
| busy | output | 1 | Frame or trailing separation in progress |

## Verification
A symbol is taken on the clock edge where `sym_valid` and `sym_ready` are both high. `line_active` takes the symbol's level on that same edge. `sym_ready` rises on the edge carrying the tick that ends the count. `busy` falls one clock after the last trailing tick. The bench drives every input at the falling edge and keeps a behavioural model that advances on each rising edge. At each falling edge it compares all three outputs against the model, so every result is checked in the cycle it is due. Directed checks add tick totals measured from acceptance to the fall of `busy`, for both end-of-data and break.

// File: rtl/vpw_pkg.sv
package vpw_pkg;

    typedef enum logic [1:0] {
        SYM_SOF   = 2'd0,
        SYM_DATA  = 2'd1,
        SYM_EOD   = 2'd2,
        SYM_BREAK = 2'd3
    } vpw_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SYM   = 2'd1,
        PH_TRAIL = 2'd2
    } vpw_phase_e;

    typedef struct packed {
        vpw_phase_e phase;
        vpw_kind_e  kind;
        logic       line;
    } vpw_state_t;

    function automatic int vpw_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // A data bit is long when its driven level differs from its value.
    function automatic logic vpw_bit_is_long(input logic level, input logic value);
        return level ^ value;
    endfunction

endpackage

// File: rtl/vpw_width_sel.sv
module vpw_width_sel
    import vpw_pkg::*;
#(
    parameter int CNT_W   = 9,
    parameter int T_SHORT = 64,
    parameter int T_LONG  = 128,
    parameter int T_SOF   = 200,
    parameter int T_EOD   = 200,
    parameter int T_BREAK = 240
) (
    input  vpw_kind_e        kind,
    input  logic             value,
    input  logic             line_now,
    output logic             level,
    output logic [CNT_W-1:0] width
);

    always_comb begin
        level = 1'b0;
        width = CNT_W'(T_EOD);
        case (kind)
            SYM_SOF: begin
                level = 1'b1;
                width = CNT_W'(T_SOF);
            end
            SYM_DATA: begin
                level = ~line_now;
                width = vpw_bit_is_long(~line_now, value) ? CNT_W'(T_LONG)
                                                          : CNT_W'(T_SHORT);
            end
            SYM_EOD: begin
                level = 1'b0;
                width = CNT_W'(T_EOD);
            end
            SYM_BREAK: begin
                level = 1'b1;
                width = CNT_W'(T_BREAK);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/vpw_tick_timer.sv
module vpw_tick_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expired
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (tick && count != '0) begin
            count <= count - 1'b1;
        end
    end

    assign expired = (count == '0);

    // R10: without a tick or a load the remaining time does not move
    assert_hold_without_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));

    // R10: an expired count never wraps on a tick
    assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count == '0) |=> (count == '0));

endmodule

// File: rtl/vpw_seq.sv
module vpw_seq
    import vpw_pkg::*;
#(
    parameter int CNT_W     = 9,
    parameter int TRAIL_EOD = 99,
    parameter int TRAIL_BRK = 299
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             sym_valid,
    input  vpw_kind_e        kind,
    input  logic             expired,
    input  logic             new_level,
    input  logic [CNT_W-1:0] new_width,
    output logic             ready,
    output logic             line,
    output logic             busy,
    output logic             load,
    output logic [CNT_W-1:0] load_val
);

    vpw_state_t st, nxt;
    logic       accept;
    logic       run_out_tail;

    always_comb begin
        ready        = (st.phase == PH_IDLE) || (st.phase == PH_SYM && expired);
        accept       = sym_valid && ready;
        run_out_tail = (st.phase == PH_SYM) && expired && tick &&
                       (st.kind == SYM_EOD || st.kind == SYM_BREAK);
        nxt          = st;
        load         = 1'b0;
        load_val     = new_width;
        if (accept) begin
            nxt.phase = PH_SYM;
            nxt.kind  = kind;
            nxt.line  = new_level;
            load      = 1'b1;
        end else if (run_out_tail) begin
            // this tick is the first of the passive extension
            nxt.phase = PH_TRAIL;
            nxt.line  = 1'b0;
            load      = 1'b1;
            load_val  = (st.kind == SYM_EOD) ? CNT_W'(TRAIL_EOD) : CNT_W'(TRAIL_BRK);
        end else if (st.phase == PH_TRAIL && expired) begin
            nxt.phase = PH_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '{phase: PH_IDLE, kind: SYM_SOF, line: 1'b0};
        end else begin
            st <= nxt;
        end
    end

    assign line = st.line;
    assign busy = (st.phase != PH_IDLE);

    // R6: the extension never drives the line active
    assert_trail_passive_R6: assert property (@(posedge clk) disable iff (rst)
        (st.phase == PH_TRAIL) |-> !line);

    // R6: busy only ends out of the trailing extension
    assert_busy_ends_in_trail_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(st.phase) == PH_TRAIL));

    // R9: the line only moves on an acceptance or on a tick ending a symbol
    assert_line_change_cause_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(line) |-> ($past(accept) || $past(st.phase == PH_SYM && tick)));

endmodule

// File: rtl/vpw_sym_encoder.sv
module vpw_sym_encoder
    import vpw_pkg::*;
#(
    parameter int T_SHORT   = 64,
    parameter int T_LONG    = 128,
    parameter int T_SOF     = 200,
    parameter int T_EOD     = 200,
    parameter int T_EOF_EXT = 80,
    parameter int T_IFS_EXT = 20,
    parameter int T_BREAK   = 240
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_us,
    input  logic       sym_valid,
    input  logic [1:0] sym_kind,
    input  logic       sym_bit,
    output logic       sym_ready,
    output logic       line_active,
    output logic       busy
);

    localparam int TRAIL_EOD = T_EOF_EXT + T_IFS_EXT - 1;
    localparam int TRAIL_BRK = T_EOD + T_EOF_EXT + T_IFS_EXT - 1;
    localparam int MAX_LEN   = vpw_max(vpw_max(T_LONG, T_SOF),
                                       vpw_max(T_BREAK, TRAIL_BRK + 1));
    localparam int CNT_W     = $clog2(MAX_LEN + 1);

    vpw_kind_e        kind;
    logic             new_level;
    logic [CNT_W-1:0] new_width;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] count;
    logic             expired;

    assign kind = vpw_kind_e'(sym_kind);

    vpw_width_sel #(
        .CNT_W  (CNT_W),
        .T_SHORT(T_SHORT),
        .T_LONG (T_LONG),
        .T_SOF  (T_SOF),
        .T_EOD  (T_EOD),
        .T_BREAK(T_BREAK)
    ) u_width (
        .kind    (kind),
        .value   (sym_bit),
        .line_now(line_active),
        .level   (new_level),
        .width   (new_width)
    );

    vpw_tick_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_us),
        .load    (load),
        .load_val(load_val),
        .count   (count),
        .expired (expired)
    );

    vpw_seq #(
        .CNT_W    (CNT_W),
        .TRAIL_EOD(TRAIL_EOD),
        .TRAIL_BRK(TRAIL_BRK)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_us),
        .sym_valid(sym_valid),
        .kind     (kind),
        .expired  (expired),
        .new_level(new_level),
        .new_width(new_width),
        .ready    (sym_ready),
        .line     (line_active),
        .busy     (busy),
        .load     (load),
        .load_val (load_val)
    );

    // R3: each accepted data bit flips the line
    assert_bit_toggles_R3: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_kind == 2'd1) |=> (line_active != $past(line_active)));

    // R2: start-of-frame goes active
    assert_sof_active_R2: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_kind == 2'd0) |=> (line_active && busy));

    // R5: end-of-data goes passive
    assert_eod_passive_R5: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_kind == 2'd2) |=> !line_active);

    // R8: break goes active
    assert_break_active_R8: assert property (@(posedge clk) disable iff (rst)
        (sym_valid && sym_ready && sym_kind == 2'd3) |=> (line_active && busy));

endmodule

// File: tb/vpw_sym_encoder_test.sv
module vpw_sym_encoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_us = 1'b0;
    logic       sym_valid = 1'b0;
    logic [1:0] sym_kind = 2'd0;
    logic       sym_bit = 1'b0;
    logic       sym_ready;
    logic       line_active;
    logic       busy;

    always #5 clk = ~clk;

    vpw_sym_encoder uut (
        .clk        (clk),
        .rst        (rst),
        .tick_us    (tick_us),
        .sym_valid  (sym_valid),
        .sym_kind   (sym_kind),
        .sym_bit    (sym_bit),
        .sym_ready  (sym_ready),
        .line_active(line_active),
        .busy       (busy)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int tick_total = 0;
    int mark = 0;

    // Behavioural reference: mode 0 idle, 1 symbol, 2 passive extension
    int m_mode = 0;
    int m_rem = 0;
    int m_kind = 0;
    bit m_line = 1'b0;

    always @(posedge clk) begin
        bit rdy;
        if (rst) begin
            m_mode = 0; m_rem = 0; m_kind = 0; m_line = 1'b0;
        end else begin
            rdy = (m_mode == 0) || (m_mode == 1 && m_rem == 0);
            if (sym_valid && rdy) begin
                m_mode = 1;
                m_kind = int'(sym_kind);
                case (m_kind)
                    0: begin m_line = 1'b1; m_rem = 200; end
                    1: begin
                        m_line = !m_line;
                        if (m_line) m_rem = sym_bit ? 64 : 128;
                        else        m_rem = sym_bit ? 128 : 64;
                    end
                    2: begin m_line = 1'b0; m_rem = 200; end
                    default: begin m_line = 1'b1; m_rem = 240; end
                endcase
            end else if (m_mode == 1 && m_rem == 0 && tick_us && m_kind >= 2) begin
                // this tick counts as the first passive tick of the extension
                m_mode = 2;
                m_line = 1'b0;
                m_rem  = (m_kind == 2) ? 99 : 299;
            end else if (m_mode == 2 && m_rem == 0) begin
                m_mode = 0;
            end else if (tick_us && m_rem > 0) begin
                m_rem = m_rem - 1;
            end
        end
    end

    function automatic string tag();
        if (m_mode == 0) return "R1";
        if (m_mode == 2) return "R6";
        case (m_kind)
            0: return "R2";
            1: return "R4";
            2: return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // one clock: compare against the model, then drive the tick for the next edge
    task automatic step();
        logic [2:0] act;
        logic [2:0] exp;
        @(negedge clk);
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog expired at cycle %0d: actual 1 expected 0", cyc);
            summary();
            $finish;
        end
        if (!rst) begin
            act = {line_active, busy, sym_ready};
            exp = {m_line, (m_mode != 0), ((m_mode == 0) || (m_mode == 1 && m_rem == 0))};
            check(act == exp, tag(), "{line,busy,ready}", int'(act), int'(exp));
        end
        tick_us = (cyc % 3 == 0);
        if (tick_us) tick_total++;
    endtask

    function automatic int ticks_applied();
        return tick_total - int'(tick_us);
    endfunction

    task automatic send(input logic [1:0] k, input logic b);
        sym_valid = 1'b1;
        sym_kind  = k;
        sym_bit   = b;
        while (!sym_ready) step();
        step();
        sym_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step();
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1: reset state
        check(!line_active && !busy && sym_ready, "R1", "line/busy/ready after reset",
              int'({line_active, busy, sym_ready}), 1);

        // R10: kinds wiggled with valid low are never taken
        sym_kind = 2'd1;
        repeat (6) step();
        sym_kind = 2'd3;
        repeat (6) step();
        check(!busy && !line_active, "R10", "idle with valid low",
              int'({busy, line_active}), 0);

        // Frame 1: start-of-frame, eight bits over both levels, end-of-data
        send(2'd0, 1'b0);
        check(line_active == 1'b1, "R2", "start-of-frame level", int'(line_active), 1);
        send(2'd1, 1'b1);
        check(line_active == 1'b0, "R3", "first bit after start-of-frame", int'(line_active), 0);
        send(2'd1, 1'b0);
        send(2'd1, 1'b0);
        send(2'd1, 1'b1);
        send(2'd1, 1'b1);
        send(2'd1, 1'b0);
        send(2'd1, 1'b1);
        send(2'd1, 1'b0);
        send(2'd2, 1'b0);
        mark = ticks_applied();
        wait_idle();
        check(ticks_applied() - mark == 300, "R6", "ticks from end-of-data to idle",
              ticks_applied() - mark, 300);

        // Frame 2: stalled start-of-frame, then a continuation after end-of-data
        send(2'd0, 1'b0);
        while (!sym_ready) step();
        repeat (40) step();
        check(line_active && sym_ready && busy, "R9", "expired symbol holds level",
              int'({line_active, sym_ready, busy}), 7);
        send(2'd1, 1'b0);
        send(2'd1, 1'b1);
        send(2'd2, 1'b0);
        send(2'd1, 1'b1);
        check(line_active && busy, "R7", "bit taken right after end-of-data",
              int'({line_active, busy}), 3);
        send(2'd1, 1'b0);
        send(2'd2, 1'b0);
        wait_idle();

        // Break and its trailing passive time
        send(2'd3, 1'b0);
        check(line_active == 1'b1, "R8", "break level", int'(line_active), 1);
        mark = ticks_applied() - 0;
        wait_idle();
        check(ticks_applied() - mark == 540, "R8", "ticks from break to idle",
              ticks_applied() - mark, 540);

        repeat (5) step();
        summary();
        $finish;
    end

endmodule